// File: doc/BRIEF.md
# DMA Controller Host Register Interface

This block is the register file that a processor sees when it programs a four-channel DMA controller. The processor talks to it over an 8-bit write bus, an 8-bit read bus, a 4-bit register address, an active-low chip select and active-low read and write strobes. Behind that port sit the per-channel 16-bit address and word count registers (each as a base/current pair), the per-channel mode settings, and the shared command, request, mask, status and temporary registers. The transfer engine uses the mask, request, command and base values that this block drives out. It reports terminal count events and temporary data back in through dedicated inputs.

Each address has one meaning for reads and another for writes. Several accesses act as commands with no data. Some of these commands are reads, and they change state when they complete. A single internal byte pointer flag decides which half of a 16-bit register the next channel access reaches. The flag flips after every such access, so two accesses in a row cover the low byte and then the high byte.

Top module: `dma_host_regs`

## Requirements
- R1: A write is taken once, in the first clock cycle in which `cs_ni` and `iow_ni` are both low and `ior_ni` is high. A longer strobe counts as one write, and a write strobe with `cs_ni` high changes nothing. `rdata_o` is 0 whenever `cs_ni` or `ior_ni` is high.
- R2: Addresses 0 to 7 reach channel `addr_i[2:1]`. `addr_i[0]`=0 selects the address register and `addr_i[0]`=1 selects the word count register.
- R3: A channel write stores the byte chosen by the pointer into both the base and the current register. The base values appear on `base_addr_o`/`base_cnt_o`, with channel n at bits [16n+15:16n]. A channel read returns the current register.
- R4: Pointer value 0 selects bits 7:0 and value 1 selects bits 15:8. The pointer flips after every channel access: at the strobe start for a write, and at the strobe release for a read. Reset leaves it at 0.
- R5: Address 8 writes the command register (`cmd_o`) and reads status. Status bits 3:0 are the sticky terminal count flags, set by `tc_i`. Status bits 7:4 are the request bits. Address 10 reads the command register.
- R6: A write to address 9 sets request bit `data[1:0]` to `data[2]`. A read of address 9 returns {4'b0, request} and drives request on `req_o`.
- R7: A write to address 10 sets mask bit `data[1:0]` to `data[2]`. A write to address 15 loads all mask bits from `data[3:0]`. A read of address 15 returns {4'b0, mask}. A read never changes the mask.
- R8: A write to address 12 clears the pointer. A read of address 12 returns 0 and sets the pointer to 1 when the strobe is released.
- R9: A write to address 13 is a master clear. It clears the pointer, command, request, terminal count flags, temporary register and mode read counter, and it sets all four mask bits. Reset gives the same state. A read of address 13 returns the temporary register, which is loaded from `tmp_data_i` when `tmp_ld_i` is high.
- R10: A write to address 14 clears every mask bit. A read of address 14 returns 0 and resets the mode read counter to 0.
- R11: A write to address 11 stores `data[7:2]` as the mode of channel `data[1:0]`. A read of address 11 returns {mode[k], k}, where k is the mode read counter. k advances by one, wrapping from 3 to 0, when each such read is released.
- R12: A status read clears the terminal count flags when the strobe is released. A `tc_i` bit that is high in that same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ior_ni | input | 1 | Read strobe, active low |
| iow_ni | input | 1 | Write strobe, active low |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data from the processor |
| rdata_o | output | 8 | Read data to the processor |
| tc_i | input | 4 | Per-channel terminal count event pulses |
| tmp_ld_i | input | 1 | Load the temporary register |
| tmp_data_i | input | 8 | Temporary register load value |
| mask_o | output | 4 | Channel mask bits |
| req_o | output | 4 | Software request bits |
| cmd_o | output | 8 | Command register |
| base_addr_o | output | 64 | Base address of every channel |
| base_cnt_o | output | 64 | Base word count of every channel |

## Verification
The bench aims at the accesses that change state. A held write strobe must flip the pointer only once; a design that acts on every strobe cycle would leave the pointer wrong and load the next byte into the wrong half. Reads that act as commands (pointer set, mode counter clear, status clear, mode counter step) must take effect only at release; a design that acts while the strobe is still low, or not at all, would return the wrong byte or mode on the following read. Master clear, the mode counter wrap from 3 to 0, and a chip select that is held high during a write strobe are also covered; these catch designs that miss a mask bit or accept a write that is not selected.

// File: rtl/dma_host_pkg.sv
package dma_host_pkg;
  localparam int unsigned NUM_CH = 4;
  localparam int unsigned DW     = 8;
  localparam int unsigned CW     = 2 * DW;
  localparam int unsigned CH_W   = $clog2(NUM_CH);
  localparam int unsigned MODE_W = DW - CH_W;

  typedef enum logic [3:0] {
    A_CMD_STAT = 4'h8,
    A_REQ      = 4'h9,
    A_MASK1    = 4'hA,
    A_MODE     = 4'hB,
    A_PTR      = 4'hC,
    A_MCLR_TMP = 4'hD,
    A_MASKCLR  = 4'hE,
    A_MASKALL  = 4'hF
  } reg_addr_e;
endpackage

// File: rtl/dma_host_decode.sv
module dma_host_decode (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       ior_ni,
  input  logic       iow_ni,
  input  logic [3:0] addr_i,
  output logic       rd_act_o,
  output logic       wr_stb_o,
  output logic       rd_end_o,
  output logic [3:0] rd_addr_o
);
  logic wr_act, wr_q, rd_q;

  assign rd_act_o = !cs_ni && !ior_ni && iow_ni;
  assign wr_act   = !cs_ni && !iow_ni && ior_ni;
  assign wr_stb_o = wr_act && !wr_q;
  // read side effects land when the strobe goes away
  assign rd_end_o = rd_q && !rd_act_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q      <= 1'b0;
      rd_q      <= 1'b0;
      rd_addr_o <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act_o;
      if (rd_act_o) rd_addr_o <= addr_i;
    end
  end
endmodule

// File: rtl/dma_host_word.sv
module dma_host_word #(
  parameter int unsigned DW = 8,
  localparam int unsigned CW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          hi_i,
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] base_o,
  output logic [CW-1:0] cur_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      cur_o  <= '0;
    end else if (wr_i) begin
      if (hi_i) begin
        base_o[CW-1:DW] <= data_i;
        cur_o[CW-1:DW]  <= data_i;
      end else begin
        base_o[DW-1:0] <= data_i;
        cur_o[DW-1:0]  <= data_i;
      end
    end
  end
endmodule

// File: rtl/dma_host_ctrl.sv
module dma_host_ctrl
  import dma_host_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_stb_i,
  input  logic [3:0]                   wr_addr_i,
  input  logic                         rd_end_i,
  input  logic [3:0]                   rd_addr_i,
  input  logic [DW-1:0]                wdata_i,
  input  logic [NUM_CH-1:0]            tc_i,
  input  logic                         tmp_ld_i,
  input  logic [DW-1:0]                tmp_data_i,
  output logic                         ptr_o,
  output logic [DW-1:0]                cmd_o,
  output logic [NUM_CH-1:0]            mask_o,
  output logic [NUM_CH-1:0]            req_o,
  output logic [NUM_CH-1:0]            tc_o,
  output logic [DW-1:0]                tmp_o,
  output logic [DW-1:0]                mode_rd_o
);
  logic [NUM_CH-1:0][MODE_W-1:0] mode_q;
  logic [CH_W-1:0]               mcnt_q;
  logic [CH_W-1:0]               wsel;

  assign wsel      = wdata_i[CH_W-1:0];
  assign mode_rd_o = {mode_q[mcnt_q], mcnt_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o  <= 1'b0;
      cmd_o  <= '0;
      mask_o <= '1;
      req_o  <= '0;
      tc_o   <= '0;
      tmp_o  <= '0;
      mode_q <= '0;
      mcnt_q <= '0;
    end else begin
      // terminal count events win over a clearing status read
      if (rd_end_i && rd_addr_i == A_CMD_STAT) tc_o <= tc_i;
      else                                     tc_o <= tc_o | tc_i;
      if (tmp_ld_i) tmp_o <= tmp_data_i;

      if (rd_end_i) begin
        if (!rd_addr_i[3]) ptr_o <= !ptr_o;
        else begin
          case (rd_addr_i)
            A_MODE:    mcnt_q <= mcnt_q + 1'b1;
            A_PTR:     ptr_o  <= 1'b1;
            A_MASKCLR: mcnt_q <= '0;
            default: ;
          endcase
        end
      end

      if (wr_stb_i) begin
        if (!wr_addr_i[3]) ptr_o <= !ptr_o;
        else begin
          case (wr_addr_i)
            A_CMD_STAT: cmd_o <= wdata_i;
            A_REQ:      req_o[wsel] <= wdata_i[CH_W];
            A_MASK1:    mask_o[wsel] <= wdata_i[CH_W];
            A_MODE:     mode_q[wsel] <= wdata_i[DW-1:CH_W];
            A_PTR:      ptr_o <= 1'b0;
            A_MCLR_TMP: begin
              ptr_o  <= 1'b0;
              cmd_o  <= '0;
              mask_o <= '1;
              req_o  <= '0;
              tc_o   <= '0;
              tmp_o  <= '0;
              mcnt_q <= '0;
            end
            A_MASKCLR:  mask_o <= '0;
            A_MASKALL:  mask_o <= wdata_i[NUM_CH-1:0];
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/dma_host_regs.sv
module dma_host_regs
  import dma_host_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_ni,
  input  logic                 ior_ni,
  input  logic                 iow_ni,
  input  logic [3:0]           addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  input  logic [NUM_CH-1:0]    tc_i,
  input  logic                 tmp_ld_i,
  input  logic [DW-1:0]        tmp_data_i,
  output logic [NUM_CH-1:0]    mask_o,
  output logic [NUM_CH-1:0]    req_o,
  output logic [DW-1:0]        cmd_o,
  output logic [NUM_CH*CW-1:0] base_addr_o,
  output logic [NUM_CH*CW-1:0] base_cnt_o
);
  localparam int unsigned NW    = 2 * NUM_CH;
  localparam int unsigned WSEL_W = $clog2(NW);

  logic                rd_act, wr_stb, rd_end, ptr;
  logic [3:0]          rd_addr;
  logic [NUM_CH-1:0]   tc;
  logic [DW-1:0]       tmp, mode_rd, status;
  logic [NW-1:0][CW-1:0] cur_w, base_w;
  logic [CW-1:0]       sel_w;

  dma_host_decode u_dec (
    .clk_i, .rst_ni, .cs_ni, .ior_ni, .iow_ni, .addr_i,
    .rd_act_o (rd_act),
    .wr_stb_o (wr_stb),
    .rd_end_o (rd_end),
    .rd_addr_o(rd_addr)
  );

  dma_host_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .wr_stb_i  (wr_stb),
    .wr_addr_i (addr_i),
    .rd_end_i  (rd_end),
    .rd_addr_i (rd_addr),
    .wdata_i,
    .tc_i,
    .tmp_ld_i,
    .tmp_data_i,
    .ptr_o     (ptr),
    .cmd_o,
    .mask_o,
    .req_o,
    .tc_o      (tc),
    .tmp_o     (tmp),
    .mode_rd_o (mode_rd)
  );

  for (genvar j = 0; j < NW; j++) begin : g_word
    dma_host_word #(.DW(DW)) u_word (
      .clk_i, .rst_ni,
      .wr_i  (wr_stb && !addr_i[3] && addr_i[WSEL_W-1:0] == WSEL_W'(j)),
      .hi_i  (ptr),
      .data_i(wdata_i),
      .base_o(base_w[j]),
      .cur_o (cur_w[j])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_out
    assign base_addr_o[c*CW +: CW] = base_w[2*c];
    assign base_cnt_o[c*CW +: CW]  = base_w[2*c+1];
  end

  assign status = {req_o, tc};
  assign sel_w  = cur_w[addr_i[WSEL_W-1:0]];

  always_comb begin
    rdata_o = '0;
    if (rd_act) begin
      if (!addr_i[3]) rdata_o = ptr ? sel_w[CW-1:DW] : sel_w[DW-1:0];
      else begin
        case (addr_i)
          A_CMD_STAT: rdata_o = status;
          A_REQ:      rdata_o = DW'(req_o);
          A_MASK1:    rdata_o = cmd_o;
          A_MODE:     rdata_o = mode_rd;
          A_MCLR_TMP: rdata_o = tmp;
          A_MASKALL:  rdata_o = DW'(mask_o);
          default:    rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_host_regs_chk.sv
module dma_host_regs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       ior_ni,
  input logic [3:0] addr_i,
  input logic [7:0] rdata_o,
  input logic [3:0] tc_i,
  input logic [3:0] mask_o,
  input logic       wr_stb,
  input logic       rd_end,
  input logic [3:0] rd_addr,
  input logic       ptr,
  input logic [7:0] status
);
  // R1
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || ior_ni) |-> rdata_o == 8'h00);
  // R4
  ptr_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb && !addr_i[3] && !rd_end) |=> ptr != $past(ptr));
  // R8
  ptr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb && addr_i == 4'hC) |=> !ptr);
  // R9
  mclr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb && addr_i == 4'hD) |=> (mask_o == 4'hF && !ptr && status == 8'h00));
  // R10
  mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb && addr_i == 4'hE) |=> mask_o == 4'h0);
  // R12
  tc_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_end && rd_addr == 4'h8 && !wr_stb && tc_i == 4'h0) |=> status[3:0] == 4'h0);
  // R7
  rd_mask_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_end && !wr_stb) |=> $stable(mask_o));
endmodule

bind dma_host_regs dma_host_regs_chk u_chk (
  .clk_i, .rst_ni, .cs_ni, .ior_ni, .addr_i, .rdata_o, .tc_i, .mask_o,
  .wr_stb, .rd_end, .rd_addr, .ptr, .status
);

// File: tb/dma_host_regs_bench.sv
`timescale 1ns/1ps
module dma_host_regs_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cs_n = 1'b1, ior_n = 1'b1, iow_n = 1'b1;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0, rdata;
  logic [3:0]  tc = '0;
  logic        tmp_ld = 1'b0;
  logic [7:0]  tmp_data = '0;
  logic [3:0]  mask, req;
  logic [7:0]  cmd;
  logic [63:0] base_addr, base_cnt;

  int vecs = 0, fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_prev = 1'b0;
  logic       done = 1'b0;

  // reference model
  logic [15:0] m_w[8];
  logic [5:0]  m_mode[4];
  logic [1:0]  m_mc;
  logic        m_ptr;
  logic [7:0]  m_cmd, m_tmp;
  logic [3:0]  m_mask, m_req, m_tc;

  always #4 clk = ~clk;

  dma_host_regs u_dma_host_regs (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ior_ni(ior_n), .iow_ni(iow_n),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .tc_i(tc),
    .tmp_ld_i(tmp_ld), .tmp_data_i(tmp_data), .mask_o(mask), .req_o(req),
    .cmd_o(cmd), .base_addr_o(base_addr), .base_cnt_o(base_cnt)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compare read data on the first sampled cycle of each read
  always @(negedge clk) begin
    logic rd_now;
    rd_now = !cs_n && !ior_n;
    if (rd_now && !rd_prev) begin
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R1: read with no expected value, got %0h expected none", rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, 64'(rdata), 64'(e));
      end
    end
    rd_prev = rd_now;
  end

  task automatic m_mclr();
    m_ptr = 0; m_cmd = 0; m_req = 0; m_tc = 0; m_tmp = 0; m_mc = 0; m_mask = 4'hF;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input int hold = 1);
    @(posedge clk); #1;
    addr = a; wdata = d; cs_n = 0; iow_n = 0;
    repeat (hold) @(posedge clk);
    #1; iow_n = 1; cs_n = 1;
    case (a)
      4'h8: m_cmd = d;
      4'h9: m_req[d[1:0]] = d[2];
      4'hA: m_mask[d[1:0]] = d[2];
      4'hB: m_mode[d[1:0]] = d[7:2];
      4'hC: m_ptr = 0;
      4'hD: m_mclr();
      4'hE: m_mask = 0;
      4'hF: m_mask = d[3:0];
      default: begin
        if (m_ptr) m_w[a[2:0]][15:8] = d; else m_w[a[2:0]][7:0] = d;
        m_ptr = !m_ptr;
      end
    endcase
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    logic [7:0] e;
    case (a)
      4'h8: begin e = {m_req, m_tc}; m_tc = 0; end
      4'h9: e = {4'h0, m_req};
      4'hA: e = m_cmd;
      4'hB: begin e = {m_mode[m_mc], m_mc}; m_mc = m_mc + 1; end
      4'hC: begin e = 0; m_ptr = 1; end
      4'hD: e = m_tmp;
      4'hE: begin e = 0; m_mc = 0; end
      4'hF: e = {4'h0, m_mask};
      default: begin
        e = m_ptr ? m_w[a[2:0]][15:8] : m_w[a[2:0]][7:0];
        m_ptr = !m_ptr;
      end
    endcase
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    addr = a; cs_n = 0; ior_n = 0;
    repeat (2) @(posedge clk);
    #1; ior_n = 1; cs_n = 1;
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) m_w[i] = 0;
    for (int i = 0; i < 4; i++) m_mode[i] = 0;
    m_mclr();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #2;
    // R9 reset state
    chk("R9 reset mask", 64'(mask), 64'hF);
    chk("R9 reset cmd", 64'(cmd), 64'h0);
    chk("R1 idle rdata", 64'(rdata), 64'h0);

    // R2 R3 R4 channel words
    wr(4'h0, 8'h34); wr(4'h0, 8'h12);
    wr(4'h7, 8'hCD); wr(4'h7, 8'hAB);
    wr(4'h4, 8'h78); wr(4'h4, 8'h56);
    chk("R3 base addr ch0", 64'(base_addr[15:0]), 64'h1234);
    chk("R3 base cnt ch3", 64'(base_cnt[63:48]), 64'hABCD);
    chk("R2 base addr ch2", 64'(base_addr[47:32]), 64'h5678);
    rd(4'h0, "R3 ch0 addr lo"); rd(4'h0, "R3 ch0 addr hi");
    rd(4'h7, "R2 ch3 cnt lo");  rd(4'h7, "R2 ch3 cnt hi");

    // R8 pointer commands
    wr(4'h1, 8'h99);            // ptr -> 1
    wr(4'hC, 8'h00);            // ptr -> 0
    rd(4'h4, "R8 clear ptr lo byte");
    rd(4'hC, "R8 set ptr read data");
    rd(4'h4, "R8 set ptr hi byte");
    chk("R4 ptr back to 0 after read", 64'(base_cnt[15:0]), 64'h0099);

    // R1 held strobe and unselected write
    wr(4'h2, 8'hEE, 3);         // one write, ptr -> 1
    wr(4'h2, 8'h11);            // high byte
    chk("R1 long strobe one access", 64'(base_addr[31:16]), 64'h11EE);
    @(posedge clk); #1;
    addr = 4'h8; wdata = 8'hFF; cs_n = 1; iow_n = 0;
    @(posedge clk); #1; iow_n = 1;
    chk("R1 no write without select", 64'(cmd), 64'h00);

    // R5 command
    wr(4'h8, 8'hA5);
    chk("R5 cmd_o", 64'(cmd), 64'hA5);
    rd(4'hA, "R5 cmd read");

    // R6 request
    wr(4'h9, 8'h06); wr(4'h9, 8'h04); wr(4'h9, 8'h01);
    chk("R6 req_o", 64'(req), 64'h5);
    rd(4'h9, "R6 req read");

    // R12 terminal count and status
    @(posedge clk); #1 tc = 4'b1010;
    @(posedge clk); #1 tc = 4'b0000;
    m_tc = 4'b1010;
    rd(4'h8, "R12 status with tc");
    rd(4'h8, "R12 status after clear");

    // R7 mask
    wr(4'hF, 8'h0F);
    wr(4'hA, 8'h01);            // clear ch1
    wr(4'hA, 8'h02);            // clear ch2
    chk("R7 mask single", 64'(mask), 64'h9);
    rd(4'hF, "R7 mask read");
    chk("R7 read keeps mask", 64'(mask), 64'h9);
    wr(4'hF, 8'hF6);
    chk("R7 mask all", 64'(mask), 64'h6);
    wr(4'hE, 8'h00);
    chk("R10 mask clear", 64'(mask), 64'h0);

    // R11 mode
    wr(4'hB, 8'h84); wr(4'hB, 8'h49); wr(4'hB, 8'hC2); wr(4'hB, 8'h2F);
    for (int i = 0; i < 5; i++) rd(4'hB, "R11 mode step");
    rd(4'hE, "R10 counter clear data");
    rd(4'hB, "R10 mode after counter clear");

    // R9 temp and master clear
    @(posedge clk); #1 tmp_ld = 1; tmp_data = 8'h3C;
    @(posedge clk); #1 tmp_ld = 0;
    m_tmp = 8'h3C;
    rd(4'hD, "R9 temp read");
    wr(4'h9, 8'h07);
    wr(4'h3, 8'h55);            // ptr -> 1
    wr(4'hD, 8'h00);
    chk("R9 mclr mask", 64'(mask), 64'hF);
    chk("R9 mclr cmd", 64'(cmd), 64'h0);
    chk("R9 mclr req", 64'(req), 64'h0);
    rd(4'hD, "R9 temp cleared");
    rd(4'h3, "R9 ptr cleared lo byte");
    rd(4'hB, "R9 mode counter cleared");

    repeat (3) @(posedge clk);
    #1;
    chk("R1 all reads consumed", 64'(exp_q.size()), 64'h0);
    finish_run();
  end
endmodule